// File: doc/BRIEF.md
# Three-Input Truth-Table Vector Unit

This unit applies one freely chosen three-input Boolean function to every bit position of three 128-bit operand vectors in a single operation. The function is given as an 8-bit truth table. At each bit position, the bits of operands A, B and C form a 3-bit index, with A as the most significant bit and C as the least significant bit. That index picks one bit of the table, and the picked bit becomes the result bit. A table for any expression can be built by combining the constants 0xF0 (A), 0xCC (B) and 0xAA (C) with the same bitwise operators.

The operation itself is purely bitwise. The element-size select only changes how the per-element write mask maps onto the vector. In 32-bit mode the vector has four elements and mask bits 0 to 3 are used. In 64-bit mode the vector has two elements, mask bits 0 and 1 are used, and bits 2 and 3 are ignored. Lanes that are masked off either keep the value of operand A (merge mode) or are forced to zero (zero mode). The result is registered, so it appears one cycle after the valid strobe.

Top module: `ttl_vec_unit`

## Requirements
- R1: Every output bit i equals bit {A[i],B[i],C[i]} of the table, where A is the index MSB and C is the LSB, provided the element holding bit i is enabled.
- R2: With all lanes enabled, table 0xF0 returns operand A, table 0xCC returns operand B and table 0xAA returns operand C.
- R3: Table 0x00 yields all zeros, 0xFF yields all ones, 0x01 yields the NOR of the three operands and 0xFE yields their OR.
- R4: Table 0xA2 computes (A | ~B) & C, and table 0x82 computes ~(A ^ B) & C.
- R5: With the size select at 0 (32-bit elements), mask bit k enables result bits [32k+31:32k], for k from 0 to 3.
- R6: With the size select at 1 (64-bit elements), mask bit k enables result bits [64k+63:64k], for k from 0 to 1. Mask bits 2 and 3 have no effect.
- R7: With the zero-mode input at 0 (merge), a disabled lane outputs the matching bits of operand A.
- R8: With the zero-mode input at 1, a disabled lane outputs zero.
- R9: The output valid flag is high exactly one cycle after each cycle with the input valid high. The output data is updated at that point and otherwise holds its value.
- R10: A synchronous active-high reset clears both the output valid flag and the output data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opa | input | 128 | Operand A (index MSB; merge source) |
| opb | input | 128 | Operand B (index middle bit) |
| opc | input | 128 | Operand C (index LSB) |
| tbl | input | 8 | Truth table selecting the function |
| wide_sel | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| lane_mask | input | 4 | Per-element write enable |
| zero_mode | input | 1 | Disabled lanes: 0 = keep A, 1 = zero |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 128 | Registered result vector |

## Verification
In every cycle the table evaluation and the lane masking act on the same bits. The bench therefore pairs tables whose unmasked result differs from operand A (0xFF, 0x00, random tables) with partial masks in both element sizes and both masking modes. Each lane is judged separately against a model that evaluates the table bit by bit. The second overlap is a new operation issued while the previous result is still on the output. Two back-to-back operations are sent, and the bench checks that each result appears in its own cycle and that the data then holds once the strobe drops.

// File: rtl/ttl_pkg.sv
package ttl_pkg;
    typedef enum logic {
        ELEM_NARROW = 1'b0,
        ELEM_WIDE   = 1'b1
    } elem_sel_e;

    typedef enum logic {
        MASK_MERGE = 1'b0,
        MASK_ZERO  = 1'b1
    } mask_mode_e;

    localparam int unsigned TBL_W = 8;
endpackage

// File: rtl/ttl_bitfunc.sv
module ttl_bitfunc #(
    parameter int unsigned VEC_W = 128
) (
    input  logic [VEC_W-1:0]         a,
    input  logic [VEC_W-1:0]         b,
    input  logic [VEC_W-1:0]         c,
    input  logic [ttl_pkg::TBL_W-1:0] tbl,
    output logic [VEC_W-1:0]         y
);
    // Each position selects one table bit with the index {a,b,c}.
    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        assign y[i] = tbl[{a[i], b[i], c[i]}];
    end
endmodule

// File: rtl/ttl_lane_en.sv
module ttl_lane_en #(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned WIDE_W   = 64,
    localparam int unsigned MASK_W  = VEC_W / NARROW_W
) (
    input  logic              wide_sel,
    input  logic [MASK_W-1:0] lane_mask,
    output logic [VEC_W-1:0]  bit_en
);
    localparam int unsigned N_NARROW = VEC_W / NARROW_W;
    localparam int unsigned N_WIDE   = VEC_W / WIDE_W;

    logic [VEC_W-1:0] narrow_en;
    logic [VEC_W-1:0] wide_en;

    for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
        assign narrow_en[k*NARROW_W +: NARROW_W] = {NARROW_W{lane_mask[k]}};
    end

    // Only the low N_WIDE mask bits take part in wide mode.
    for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
        assign wide_en[k*WIDE_W +: WIDE_W] = {WIDE_W{lane_mask[k]}};
    end

    assign bit_en = (wide_sel == ttl_pkg::ELEM_WIDE) ? wide_en : narrow_en;
endmodule

// File: rtl/ttl_lane_merge.sv
module ttl_lane_merge #(
    parameter int unsigned VEC_W = 128
) (
    input  logic [VEC_W-1:0] fn_res,
    input  logic [VEC_W-1:0] keep,
    input  logic [VEC_W-1:0] bit_en,
    input  logic             zero_mode,
    output logic [VEC_W-1:0] y
);
    logic [VEC_W-1:0] fill;

    always_comb begin
        fill = (zero_mode == ttl_pkg::MASK_ZERO) ? '0 : keep;
        y    = (fn_res & bit_en) | (fill & ~bit_en);
    end
endmodule

// File: rtl/ttl_vec_unit.sv
module ttl_vec_unit #(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned WIDE_W   = 64,
    localparam int unsigned MASK_W  = VEC_W / NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  opa,
    input  logic [VEC_W-1:0]  opb,
    input  logic [VEC_W-1:0]  opc,
    input  logic [7:0]        tbl,
    input  logic              wide_sel,
    input  logic [MASK_W-1:0] lane_mask,
    input  logic              zero_mode,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_data
);
    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } out_st_t;

    out_st_t          st_d;
    out_st_t          st_q;
    logic [VEC_W-1:0] fn_res;
    logic [VEC_W-1:0] bit_en;
    logic [VEC_W-1:0] merged;

    ttl_bitfunc #(.VEC_W(VEC_W)) u_func (
        .a   (opa),
        .b   (opb),
        .c   (opc),
        .tbl (tbl),
        .y   (fn_res)
    );

    ttl_lane_en #(
        .VEC_W    (VEC_W),
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_en (
        .wide_sel  (wide_sel),
        .lane_mask (lane_mask),
        .bit_en    (bit_en)
    );

    ttl_lane_merge #(.VEC_W(VEC_W)) u_merge (
        .fn_res    (fn_res),
        .keep      (opa),
        .bit_en    (bit_en),
        .zero_mode (zero_mode),
        .y         (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
endmodule

// File: rtl/ttl_vec_unit_chk.sv
module ttl_vec_unit_chk #(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned NARROW_W = 32,
    localparam int unsigned MASK_W  = VEC_W / NARROW_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [VEC_W-1:0]  opa,
    input logic [7:0]        tbl,
    input logic              wide_sel,
    input logic [MASK_W-1:0] lane_mask,
    input logic              zero_mode,
    input logic              out_valid,
    input logic [VEC_W-1:0]  out_data
);
    // R9: the strobe reappears on the output one cycle later
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R10: reset clears the output register
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2: the A identity table with every lane enabled
    a_r2_identity_a: assert property (@(posedge clk) disable iff (rst)
        (in_valid && tbl == 8'hF0 && (&lane_mask)) |=> out_data == $past(opa));

    // R3: the all-ones table with every narrow lane enabled
    a_r3_all_ones: assert property (@(posedge clk) disable iff (rst)
        (in_valid && tbl == 8'hFF && !wide_sel && (&lane_mask)) |=> (&out_data));

    // R7: merge keeps operand A in a disabled narrow lane 0
    a_r7_merge_lane0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !zero_mode && !wide_sel && !lane_mask[0])
        |=> out_data[NARROW_W-1:0] == $past(opa[NARROW_W-1:0]));

    // R8: zero masking clears a disabled narrow lane 0
    a_r8_zero_lane0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zero_mode && !wide_sel && !lane_mask[0])
        |=> out_data[NARROW_W-1:0] == '0);
endmodule

bind ttl_vec_unit ttl_vec_unit_chk #(
    .VEC_W    (VEC_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opa       (opa),
    .tbl       (tbl),
    .wide_sel  (wide_sel),
    .lane_mask (lane_mask),
    .zero_mode (zero_mode),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_ttl_vec_unit.sv
module tb_ttl_vec_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [127:0] opc = '0;
    logic [7:0]   tbl = '0;
    logic         wide_sel = 1'b0;
    logic [3:0]   lane_mask = '0;
    logic         zero_mode = 1'b0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ttl_vec_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opa(opa), .opb(opb), .opc(opc), .tbl(tbl),
        .wide_sel(wide_sel), .lane_mask(lane_mask), .zero_mode(zero_mode),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [7:0] t;
        logic       w;
        logic [3:0] m;
        logic       z;
    } stim_t;

    // Table-driven cases: expected values come from the bit-level model.
    localparam stim_t STIM [12] = '{
        '{8'h96, 1'b0, 4'b1111, 1'b0}, // R1 three-way xor
        '{8'hE8, 1'b0, 4'b1111, 1'b0}, // R1 majority
        '{8'hCA, 1'b1, 4'b0011, 1'b0}, // R1 select
        '{8'h42, 1'b0, 4'b1111, 1'b1}, // R1 add-overflow detect table
        '{8'h18, 1'b1, 4'b0011, 1'b1}, // R1 sub-overflow detect table
        '{8'h5A, 1'b0, 4'b0110, 1'b0}, // R5 R7 middle lanes
        '{8'h3C, 1'b0, 4'b1001, 1'b1}, // R5 R8 outer lanes
        '{8'h7F, 1'b1, 4'b0010, 1'b0}, // R6 R7 upper half only
        '{8'h81, 1'b1, 4'b1101, 1'b1}, // R6 R8 lane0 only, bits 3:2 ignored
        '{8'h00, 1'b0, 4'b0000, 1'b0}, // R7 nothing enabled
        '{8'hFF, 1'b1, 4'b1110, 1'b1}, // R6 R8
        '{8'hA5, 1'b0, 4'b1011, 1'b0}  // R5 R7
    };

    function automatic logic [127:0] model(input logic [7:0] t, input logic w,
                                           input logic [3:0] m, input logic z,
                                           input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] c);
        logic [127:0] r;
        for (int i = 0; i < 128; i++) begin
            int  lane;
            logic f;
            f    = t[{a[i], b[i], c[i]}];
            lane = w ? (i / 64) : (i / 32);
            r[i] = m[lane] ? f : (z ? 1'b0 : a[i]);
        end
        return r;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: drive at a falling edge, sample at the next falling edge.
    task automatic issue(input logic [7:0] t, input logic w, input logic [3:0] m,
                         input logic z, input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] c, output logic [127:0] res);
        @(negedge clk);
        in_valid = 1'b1; tbl = t; wide_sel = w; lane_mask = m; zero_mode = z;
        opa = a; opb = b; opc = c;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R9 valid after strobe", out_valid, 1'b1);
        res = out_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, c, r, held;
        void'($urandom(17));
        repeat (3) @(negedge clk);
        // R10 reset state
        check_bit("R10 valid in reset", out_valid, 1'b0);
        check_vec("R10 data in reset", out_data, '0);
        rst = 1'b0;

        for (int n = 0; n < 12; n++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            issue(STIM[n].t, STIM[n].w, STIM[n].m, STIM[n].z, a, b, c, r);
            check_vec("R1 table walk", r,
                      model(STIM[n].t, STIM[n].w, STIM[n].m, STIM[n].z, a, b, c));
        end

        // R1 random tables, random masks and modes
        for (int n = 0; n < 20; n++) begin
            logic [7:0] t;
            logic [3:0] m;
            logic w, z;
            t = 8'($urandom); m = 4'($urandom); w = 1'($urandom); z = 1'($urandom);
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            issue(t, w, m, z, a, b, c, r);
            check_vec("R1 random", r, model(t, w, m, z, a, b, c));
        end

        a = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        b = 128'hF0F0_0F0F_AAAA_5555_3333_CCCC_0000_FFFF;
        c = 128'h8001_7FFE_DEAD_BEEF_1234_5678_9ABC_DEF0;

        // R2 identity tables
        issue(8'hF0, 1'b0, 4'hF, 1'b0, a, b, c, r); check_vec("R2 table F0 gives A", r, a);
        issue(8'hCC, 1'b1, 4'h3, 1'b1, a, b, c, r); check_vec("R2 table CC gives B", r, b);
        issue(8'hAA, 1'b0, 4'hF, 1'b1, a, b, c, r); check_vec("R2 table AA gives C", r, c);

        // R3 constants, NOR, OR
        issue(8'h00, 1'b0, 4'hF, 1'b0, a, b, c, r); check_vec("R3 table 00", r, '0);
        issue(8'hFF, 1'b0, 4'hF, 1'b0, a, b, c, r); check_vec("R3 table FF", r, '1);
        issue(8'h01, 1'b0, 4'hF, 1'b0, a, b, c, r); check_vec("R3 table 01 NOR", r, ~(a | b | c));
        issue(8'hFE, 1'b1, 4'h3, 1'b0, a, b, c, r); check_vec("R3 table FE OR", r, a | b | c);

        // R4 composed expressions
        issue(8'hA2, 1'b0, 4'hF, 1'b0, a, b, c, r); check_vec("R4 table A2", r, (a | ~b) & c);
        issue(8'h82, 1'b0, 4'hF, 1'b0, a, b, c, r); check_vec("R4 table 82", r, ~(a ^ b) & c);

        // R5 R7 narrow lanes 0 and 2 enabled, merge
        issue(8'hFF, 1'b0, 4'b0101, 1'b0, a, b, c, r);
        check_vec("R5 R7 narrow merge", r, {a[127:96], 32'hFFFF_FFFF, a[63:32], 32'hFFFF_FFFF});
        // R5 R8 narrow lanes 1 and 3 enabled, zero
        issue(8'hFF, 1'b0, 4'b1010, 1'b1, a, b, c, r);
        check_vec("R5 R8 narrow zero", r, {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0});
        // R6 wide: bit1 clear disables the upper half, bits 3:2 ignored
        issue(8'hFF, 1'b1, 4'b1101, 1'b0, a, b, c, r);
        check_vec("R6 R7 wide merge", r, {a[127:64], 64'hFFFF_FFFF_FFFF_FFFF});
        issue(8'hFF, 1'b1, 4'b1100, 1'b1, a, b, c, r);
        check_vec("R6 R8 wide mask high bits ignored", r, '0);

        // R9 back-to-back operations and hold
        @(negedge clk);
        in_valid = 1'b1; tbl = 8'hF0; wide_sel = 1'b0; lane_mask = 4'hF; zero_mode = 1'b0;
        opa = a; opb = b; opc = c;
        @(negedge clk);
        check_bit("R9 first of pair valid", out_valid, 1'b1);
        check_vec("R9 first of pair data", out_data, a);
        tbl = 8'hCC;
        @(negedge clk);
        in_valid = 1'b0; tbl = 8'h00; opa = '0;
        check_bit("R9 second of pair valid", out_valid, 1'b1);
        check_vec("R9 second of pair data", out_data, b);
        held = out_data;
        @(negedge clk);
        check_bit("R9 valid drops", out_valid, 1'b0);
        check_vec("R9 data holds", out_data, held);
        @(negedge clk);
        check_vec("R9 data still holds", out_data, held);

        // R10 reset after activity
        issue(8'hFF, 1'b0, 4'hF, 1'b0, a, b, c, r);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check_bit("R10 valid cleared", out_valid, 1'b0);
        check_vec("R10 data cleared", out_data, '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule